// File: doc/BRIEF.md
# Transmit Frame Fetch Channel with One-Deep Queue

This block is the memory-facing half of an Ethernet transmitter. Software programs a frame by writing the byte address of the frame's first byte and then its byte length through a small register port. The length write is what launches the frame. The channel then reads the frame from contiguous memory as 32-bit words over a request/grant master port. It stores each word in a seven-entry FIFO. Once enough data is buffered, it raises a go signal to the downstream transmit engine.

The first byte of a frame may sit at any byte offset. Each FIFO entry is realigned so that its first valid byte is in lane 0. Every entry carries a count of valid bytes, so leading bytes before the start and trailing bytes past the end never reach the engine. While one frame is in progress, software may program one more frame. That frame waits in a single queue slot and takes over as soon as the current frame's last word has been consumed. A further length write while the slot is occupied is dropped and flagged. If the engine asks for a word while the FIFO is empty, a transmit-error pulse reports the underrun.

Top module: `txq_dma_channel`

## Requirements
- R1: Register select 0 stages a start byte address. Select 1 takes a length from the low LEN_W bits of the write data and starts a frame from the staged address when the channel is idle. A length of zero is ignored.
- R2: `memAddr` is the word-aligned address of the word being fetched. It starts at the start address with its two low bits cleared and steps by 4 on each grant. `memReq` stays high until `memGnt`, and `memRdata` is captured in the grant cycle.
- R3: The FIFO holds at most 7 words. With the FIFO full and no word taken, `memReq` is low and no further word is fetched.
- R4: `txGo` rises only after 3 words are buffered, or after every word of a shorter frame has been fetched. It stays high until the frame's last word is popped.
- R5: In each word at the engine port, byte lane 0 (bits 7:0) holds the next frame byte. `txBytes` (1 to 4) gives the number of valid low lanes, unused lanes read zero, and `txLast` marks the final word.
- R6: A length write while busy with the queue slot free queues the frame. Status bit 0 (slot free) reads 0 while a frame is queued, and the queued address and length do not change.
- R7: A non-zero length write while a frame is queued is ignored and sets status bit 1 (overflow). Writing select 2 with bit 1 set clears it.
- R8: `txDone` pulses for one cycle, in the cycle after the last word of a frame is popped. In that same cycle a queued frame becomes the current frame: its length reads back on select 1 and its fetch begins.
- R9: Select 0 reads the current fetch byte address. This is the start address until the first grant, then the next word address. Select 1 reads the current frame's total length. Select 2 reads status {bit 2 busy, bit 1 overflow, bit 0 slot free}.
- R10: A `txPop` while `txGo` is high and the FIFO is empty pulses `txErr` in the next cycle and consumes no word.
- R11: After reset, `memReq`, `txGo` and `txValid` are low and status reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 address, 1 length, 2 status |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for the selected register |
| memReq | output | 1 | Word fetch request |
| memAddr | output | ADDR_W | Word-aligned fetch address |
| memGnt | input | 1 | Grant; read data is valid in this cycle |
| memRdata | input | 32 | Read data, byte 0 in bits 7:0 |
| txGo | output | 1 | Start/continue indication to the transmit engine |
| txValid | output | 1 | A FIFO word is available |
| txData | output | 32 | Realigned frame bytes |
| txBytes | output | 3 | Valid byte count of the head word |
| txLast | output | 1 | Head word ends the frame |
| txPop | input | 1 | Engine takes the head word |
| txDone | output | 1 | Frame completion pulse |
| txErr | output | 1 | Underrun pulse |

## Verification
Several properties are checked by assertions on every cycle. A request is held until its grant, and the fetch address steps one word per grant. The go signal never rises below the threshold unless the frame is fully fetched. The FIFO never overflows or underflows. A queued frame stays stable, and an extra length write while a frame is queued sets the overflow flag. Only the bench scenarios can show end-to-end properties: that the realigned bytes, lane counts and last markers reproduce the frame exactly for odd offsets and short lengths, that the queued frame follows the first one and a dropped third one is never sent, and that an underrun pop leaves the next word intact.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_STAT = 2'd2
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       push;
    logic       pop;
    logic [1:0] shiftOff;
    logic [2:0] pushBytes;
    logic       pushLast;
  } strobe_t;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic [2:0]        bytes;
    logic              last;
  } entry_t;
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DEPTH = 7,
  parameter int WIDTH = 36,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= wrData;
  end

  assign rdData = store[rdPtr];
  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (!full || pop)); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty); // R10
endmodule

// File: rtl/txq_datapath.sv
module txq_datapath
  import txq_pkg::*;
#(
  parameter int FIFO_DEPTH = 7,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] txData,
  output logic [2:0]        txBytes,
  output logic              txLast,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic [CNT_W-1:0]  fifoCnt
);
  localparam int ENTRY_W = $bits(entry_t);

  logic [WORD_W-1:0] shifted;
  logic [WORD_W-1:0] aligned;
  entry_t            wrEntry;
  entry_t            rdEntry;
  logic [ENTRY_W-1:0] rdRaw;

  // drop the leading bytes below the start offset
  assign shifted = memRdata >> {stb.shiftOff, 3'b000};

  // keep only the valid low lanes, zero the rest
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign aligned[lane*8 +: 8] = (3'(lane) < stb.pushBytes) ? shifted[lane*8 +: 8] : 8'h00;
  end

  always_comb begin
    wrEntry.data  = aligned;
    wrEntry.bytes = stb.pushBytes;
    wrEntry.last  = stb.pushLast;
  end

  txq_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) i_fifo (
    .clk    (clk),
    .rstN   (rstN),
    .push   (stb.push),
    .pop    (stb.pop),
    .wrData (wrEntry),
    .rdData (rdRaw),
    .count  (fifoCnt),
    .empty  (fifoEmpty),
    .full   (fifoFull)
  );

  assign rdEntry = entry_t'(rdRaw);
  assign txData  = rdEntry.data;
  assign txBytes = rdEntry.bytes;
  assign txLast  = rdEntry.last;

  AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (stb.pushBytes != 3'd0 && stb.pushBytes <= 3'd4)); // R5
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 12,
  parameter int FIFO_DEPTH  = 7,
  parameter int START_WORDS = 3,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memGnt,
  input  logic              txPop,
  output logic              txGo,
  output logic              txDone,
  output logic              txErr,
  input  logic [CNT_W-1:0]  fifoCnt,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              headLast,
  output strobe_t           stb
);
  logic              active;
  logic [ADDR_W-1:0] addrStage;
  logic [ADDR_W-1:0] fetchPtr;
  logic [LEN_W-1:0]  fetchRem;
  logic [LEN_W-1:0]  curLen;
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [LEN_W-1:0]  pendLen;
  logic              ovf;

  logic              lenWr, lenOk, takeNew, ovfHit;
  logic [LEN_W-1:0]  newLen;
  logic              popFire, underrun, frameDone, grantFire;
  logic [2:0]        room, take;
  logic              lastWord;

  always_comb begin
    lenWr     = regWr && (regSel == SEL_LEN);
    newLen    = regWdata[LEN_W-1:0];
    lenOk     = (newLen != '0);
    takeNew   = lenWr && lenOk && !pendValid;
    ovfHit    = lenWr && lenOk && pendValid;
    popFire   = txPop && txGo && !fifoEmpty;
    underrun  = txPop && txGo && fifoEmpty;
    frameDone = popFire && headLast;
    memReq    = active && (fetchRem != '0) && !fifoFull;
    grantFire = memReq && memGnt;
    room      = 3'd4 - {1'b0, fetchPtr[1:0]};
    lastWord  = (fetchRem <= LEN_W'(room));
    take      = lastWord ? fetchRem[2:0] : room;
  end

  assign memAddr = {fetchPtr[ADDR_W-1:2], 2'b00};

  always_comb begin
    stb.push      = grantFire;
    stb.pop       = popFire;
    stb.shiftOff  = fetchPtr[1:0];
    stb.pushBytes = take;
    stb.pushLast  = lastWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      addrStage <= '0;
      fetchPtr  <= '0;
      fetchRem  <= '0;
      curLen    <= '0;
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendLen   <= '0;
      ovf       <= 1'b0;
      txGo      <= 1'b0;
      txDone    <= 1'b0;
      txErr     <= 1'b0;
    end else begin
      txDone <= frameDone;
      txErr  <= underrun;

      if (regWr && regSel == SEL_ADDR) addrStage <= regWdata[ADDR_W-1:0];

      if (ovfHit) ovf <= 1'b1;
      else if (regWr && regSel == SEL_STAT && regWdata[1]) ovf <= 1'b0;

      if (grantFire) begin
        fetchPtr <= {fetchPtr[ADDR_W-1:2] + 1'b1, 2'b00};
        fetchRem <= fetchRem - LEN_W'(take);
      end

      if (!txGo && active && (fifoCnt >= CNT_W'(START_WORDS) || fetchRem == '0))
        txGo <= 1'b1;

      if (!active) begin
        if (takeNew) begin
          active   <= 1'b1;
          curLen   <= newLen;
          fetchPtr <= addrStage;
          fetchRem <= newLen;
        end
      end else if (frameDone) begin
        txGo <= 1'b0;
        if (pendValid) begin
          pendValid <= 1'b0;
          curLen    <= pendLen;
          fetchPtr  <= pendAddr;
          fetchRem  <= pendLen;
        end else if (takeNew) begin
          curLen   <= newLen;
          fetchPtr <= addrStage;
          fetchRem <= newLen;
        end else begin
          active <= 1'b0;
        end
      end else if (takeNew) begin
        pendValid <= 1'b1;
        pendAddr  <= addrStage;
        pendLen   <= newLen;
      end
    end
  end

  always_comb begin
    case (regSel)
      SEL_ADDR: regRdata = WORD_W'(fetchPtr);
      SEL_LEN:  regRdata = WORD_W'(curLen);
      SEL_STAT: regRdata = {{(WORD_W-3){1'b0}}, active, ovf, !pendValid};
      default:  regRdata = '0;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memGnt |=> memAddr == $past(memAddr) + ADDR_W'(4)); // R2
  AST_GO_THRESH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txGo) |-> ($past(fifoCnt) >= CNT_W'(START_WORDS)) || ($past(fetchRem) == '0)); // R4
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    pendValid && !frameDone |=> pendValid && $stable(pendLen) && $stable(pendAddr)); // R6
  AST_QUEUE_OVF: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regSel == SEL_LEN && regWdata[LEN_W-1:0] != '0 && pendValid |=> ovf); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone); // R8
  AST_ERR_SRC: assert property (@(posedge clk) disable iff (!rstN)
    txErr |-> $past(txGo) && $past(fifoEmpty)); // R10
endmodule

// File: rtl/txq_dma_channel.sv
module txq_dma_channel
  import txq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 12,
  parameter int FIFO_DEPTH  = 7,
  parameter int START_WORDS = 3,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memGnt,
  input  logic [31:0]       memRdata,
  output logic              txGo,
  output logic              txValid,
  output logic [31:0]       txData,
  output logic [2:0]        txBytes,
  output logic              txLast,
  input  logic              txPop,
  output logic              txDone,
  output logic              txErr
);
  strobe_t          stb;
  logic [CNT_W-1:0] fifoCnt;
  logic             fifoEmpty, fifoFull;

  txq_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH), .START_WORDS(START_WORDS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .regWr(regWr), .regSel(regSel), .regWdata(regWdata), .regRdata(regRdata),
    .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt),
    .txPop(txPop), .txGo(txGo), .txDone(txDone), .txErr(txErr),
    .fifoCnt(fifoCnt), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .headLast(txLast),
    .stb(stb)
  );

  txq_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdata(memRdata),
    .txData(txData), .txBytes(txBytes), .txLast(txLast),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fifoCnt(fifoCnt)
  );

  assign txValid = !fifoEmpty;
endmodule

// File: tb/test_txq_dma_channel.sv
module test_txq_dma_channel;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memGnt;
  logic [31:0] memRdata;
  logic        txGo, txValid, txLast, txDone, txErr;
  logic [31:0] txData;
  logic [2:0]  txBytes;
  logic        txPop = 1'b0;

  int checkCnt = 0;
  int failCnt  = 0;
  int gntCount = 0;
  int gntLimit = 0;
  logic [31:0] expPtr;
  int          expRem;
  localparam int FREE = 32'h7fff_ffff;

  txq_dma_channel i_txq_dma_channel (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memAddr(memAddr), .memGnt(memGnt),
    .memRdata(memRdata), .txGo(txGo), .txValid(txValid), .txData(txData),
    .txBytes(txBytes), .txLast(txLast), .txPop(txPop), .txDone(txDone), .txErr(txErr)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] byteAt(input logic [31:0] a);
    return a[7:0] ^ 8'h5A ^ {a[9:8], 6'b0};
  endfunction

  assign memGnt   = memReq && (gntCount < gntLimit);
  assign memRdata = {byteAt(memAddr + 32'd3), byteAt(memAddr + 32'd2),
                     byteAt(memAddr + 32'd1), byteAt(memAddr)};

  always @(posedge clk) if (memGnt) gntCount <= gntCount + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWdata = data;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = regRdata;
  endtask

  task automatic expectFrame(input logic [31:0] addr, input int len);
    expPtr = addr;
    expRem = len;
  endtask

  // pops up to n words (0 = to the end of the frame), comparing each
  task automatic drainWords(input int n, input string req);
    int t = 0;
    int popped = 0;
    bit bad = 0;
    logic [31:0] badAct = '0, badExp = '0;
    while (!txGo && t < 2000) begin @(negedge clk); t++; end
    while (expRem > 0 && (n == 0 || popped < n) && t < 4000) begin
      if (txValid) begin
        int room = 4 - int'(expPtr[1:0]);
        int eb = (expRem < room) ? expRem : room;
        logic [31:0] ew = '0;
        for (int i = 0; i < 4; i++) if (i < eb) ew[i*8 +: 8] = byteAt(expPtr + 32'(i));
        if (!bad && (txData !== ew || txBytes !== 3'(eb) || txLast !== (expRem == eb))) begin
          bad = 1; badAct = txData; badExp = ew;
        end
        txPop = 1'b1;
        @(negedge clk);
        txPop = 1'b0;
        expPtr = expPtr + 32'(eb);
        expRem = expRem - eb;
        popped++;
      end else begin
        @(negedge clk);
        t++;
      end
    end
    chk(!bad && t < 4000, req, "frame words", badAct, badExp);
    if (expRem == 0) chk(txDone === 1'b1, "R8", "done pulse", 32'(txDone), 32'd1);
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk(memReq === 1'b0 && txGo === 1'b0 && txValid === 1'b0, "R11", "idle outputs",
        {29'd0, memReq, txGo, txValid}, 32'd0);
    regRead(2'd2, v);
    chk(v === 32'd1, "R11", "status after reset", v, 32'd1);
  endtask

  task automatic testZeroLength();
    logic [31:0] v;
    gntLimit = gntCount;
    regWrite(2'd0, 32'h40);
    regWrite(2'd1, 32'd0);
    @(negedge clk);
    regRead(2'd2, v);
    chk(v === 32'd1 && memReq === 1'b0, "R1", "zero length ignored", v, 32'd1);
  endtask

  task automatic testAligned();
    gntLimit = FREE;
    regWrite(2'd0, 32'h100);
    regWrite(2'd1, 32'd16);
    expectFrame(32'h100, 16);
    drainWords(0, "R1 R5 aligned frame");
  endtask

  task automatic testThreshold();
    logic [31:0] v;
    gntLimit = gntCount + 2;
    regWrite(2'd0, 32'h200);
    regWrite(2'd1, 32'd40);
    repeat (10) @(negedge clk);
    chk(txGo === 1'b0 && txValid === 1'b1, "R4", "no go below three words",
        {30'd0, txGo, txValid}, 32'd1);
    chk(memReq === 1'b1 && memAddr === 32'h208, "R2", "request held at next word", memAddr, 32'h208);
    regRead(2'd0, v);
    chk(v === 32'h208, "R9", "fetch address readback", v, 32'h208);
    regRead(2'd1, v);
    chk(v === 32'd40, "R9", "length readback", v, 32'd40);
    gntLimit = gntCount + 1;
    repeat (3) @(negedge clk);
    chk(txGo === 1'b1, "R4", "go after third word", 32'(txGo), 32'd1);
    gntLimit = FREE;
    expectFrame(32'h200, 40);
    drainWords(0, "R4 threshold frame");
  endtask

  task automatic testUnaligned();
    logic [31:0] v;
    gntLimit = gntCount;
    regWrite(2'd0, 32'h303);
    regWrite(2'd1, 32'd6);
    regRead(2'd0, v);
    chk(v === 32'h303, "R9", "unaligned start readback", v, 32'h303);
    chk(memAddr === 32'h300, "R2", "aligned fetch address", memAddr, 32'h300);
    gntLimit = FREE;
    expectFrame(32'h303, 6);
    drainWords(0, "R5 unaligned frame");
    regWrite(2'd0, 32'h321);
    regWrite(2'd1, 32'd2);
    expectFrame(32'h321, 2);
    drainWords(0, "R4 R5 short single word");
  endtask

  task automatic testFull();
    logic [31:0] v;
    gntLimit = FREE;
    regWrite(2'd0, 32'h800);
    regWrite(2'd1, 32'd64);
    repeat (20) @(negedge clk);
    regRead(2'd0, v);
    chk(memReq === 1'b0 && v === 32'h81C, "R3", "stops at seven words", v, 32'h81C);
    expectFrame(32'h800, 64);
    drainWords(0, "R3 full fifo frame");
  endtask

  task automatic testQueue();
    logic [31:0] v;
    gntLimit = gntCount;
    regWrite(2'd0, 32'h400);
    regWrite(2'd1, 32'd12);
    regWrite(2'd0, 32'h500);
    regWrite(2'd1, 32'd9);
    regRead(2'd2, v);
    chk(v === 32'd4, "R6", "slot taken", v, 32'd4);
    regWrite(2'd0, 32'h600);
    regWrite(2'd1, 32'd20);
    regRead(2'd2, v);
    chk(v === 32'd6, "R7", "overflow flagged", v, 32'd6);
    gntLimit = FREE;
    expectFrame(32'h400, 12);
    drainWords(0, "R6 first frame");
    regRead(2'd1, v);
    chk(v === 32'd9, "R8", "queued length promoted", v, 32'd9);
    regRead(2'd2, v);
    chk(v === 32'd7, "R8", "status after promotion", v, 32'd7);
    expectFrame(32'h500, 9);
    drainWords(0, "R6 queued frame");
    repeat (10) @(negedge clk);
    regRead(2'd2, v);
    chk(v === 32'd3 && memReq === 1'b0 && txGo === 1'b0, "R7", "third frame dropped", v, 32'd3);
    regWrite(2'd2, 32'd2);
    regRead(2'd2, v);
    chk(v === 32'd1, "R7", "overflow cleared", v, 32'd1);
  endtask

  task automatic testUnderrun();
    logic [31:0] hold;
    gntLimit = gntCount + 3;
    regWrite(2'd0, 32'h700);
    regWrite(2'd1, 32'd24);
    expectFrame(32'h700, 24);
    drainWords(3, "R10 before underrun");
    chk(txValid === 1'b0 && txGo === 1'b1, "R10", "fifo drained", {30'd0, txValid, txGo}, 32'd1);
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
    chk(txErr === 1'b1, "R10", "error pulse", 32'(txErr), 32'd1);
    @(negedge clk);
    chk(txErr === 1'b0, "R10", "error is one cycle", 32'(txErr), 32'd0);
    hold = 32'(expRem);
    chk(hold === 32'd12, "R10", "no word consumed", hold, 32'd12);
    gntLimit = FREE;
    drainWords(0, "R10 after underrun");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroLength();
    testAligned();
    testThreshold();
    testUnaligned();
    testFull();
    testQueue();
    testUnderrun();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule